// File: doc/BRIEF.md
# Quad DAC serial command interface

This block is the digital front end of a four-channel voltage-output converter. A host sends 32-bit frames over three wires: an active-low frame strobe, a serial clock and a data line. Each frame carries a command, a channel address and a straight-binary code. The block keeps two registers per channel. The staged register takes new codes. The live register drives the converter core. Around these sit a power-down state with a mode, a two-bit clear-code selection, a per-channel transparency mask and a chaining enable. When chaining is on, the bit that leaves the top of the frame register is presented on a serial output, so devices can be wired in series.

The serial pins are sampled on the block clock `clk`, which must run well above the serial clock. The pins are assumed to be synchronous to `clk`. For each channel, the output is the live code, forced to zero while that channel is powered down. The output also includes fifteen thermometer-coded segment enables, decoded from the four most significant bits of that code, for a segmented core. The resolution `RES` is 12, 14 or 16 bits.

Top module: `qdac_cmd_if`

## Requirements
- R1: After `rst_n` is released, every channel code is zero and every segment enable is zero. `pwr_dn`, `pd_mode`, `clr_sel` and `sdo` are also zero.
- R2: While `sync_n` is low, a bit is taken from `sdi`, MSB first, at each falling edge of `sclk`. Frame bits 31:28 are ignored, bits 27:24 are the command, bits 23:20 are the address, and bits 19 down to 20-RES are the code. The remaining low bits are ignored except where a command names them. The frame is executed when the 32nd bit is taken, and the outputs show the result one `clk` cycle later.
- R3: If `sync_n` rises before 32 bits have been taken, the partial frame is dropped and nothing changes. Bits after the 32nd are ignored until `sync_n` goes high.
- R4: Addresses 0, 1, 2 and 3 select channel 0, 1, 2 and 3. Address 15 selects all four channels. Any other address makes commands 0 to 3 do nothing.
- R5: Command 0 loads the code into the staged register of each selected channel. A selected channel whose load-mask bit is 1 also takes the code into its live register. Command 1 copies staged into live for each selected channel. Command 3 loads both registers of each selected channel.
- R6: Command 2 loads the staged register of each selected channel and then copies staged into live on all four channels.
- R7: Command 4 uses frame bits 3:0 as a channel mask and bits 5:4 as a mode. For each masked channel, a nonzero mode powers the channel down and mode 0 powers it up. A nonzero mode is stored in `pd_mode`. A powered-down channel outputs code 0 and keeps its live register.
- R8: Command 5 stores frame bits 1:0 in `clr_sel`. Command 6 stores frame bits 3:0 as the load mask, with bit i belonging to channel i.
- R9: Command 7 returns all registers to the state of R1.
- R10: Command 8 stores frame bit 0 as the chain enable. While the enable is 1, `sdo` takes bit 31 of the frame register at each rising edge of `sclk`. While it is 0, `sdo` is 0.
- R11: Segment enable k of a channel is 1 exactly when the top four bits of that channel's output code, read as a number, exceed k.
- R12: Commands 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| dac_code | output | 4*RES | Channel codes, channel i in bits i*RES +: RES |
| seg | output | 60 | Segment enables, channel i in bits i*15 +: 15 |
| pwr_dn | output | 4 | Power-down state per channel |
| pd_mode | output | 2 | Last nonzero power-down mode |
| clr_sel | output | 2 | Clear-code selection |

## Verification
The bench builds the block with RES set to 12. In this setting eight trailing bits of every frame are ignored. The top four bits of the code then land in frame bits 19:16, while the low bits used by commands 4, 5, 6 and 8 lie in the ignored tail. Random frames mix all commands, valid and invalid addresses and random codes, so staged and live registers drift apart across channels. Directed frames then cover truncated frames, chained output, power-down masking and the reset command.

// File: rtl/qdac_cmd_if.sv
module qdac_cmd_if #(
  parameter int RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic [4*RES-1:0] dac_code,
  output logic [59:0]      seg,
  output logic [3:0]       pwr_dn,
  output logic [1:0]       pd_mode,
  output logic [1:0]       clr_sel
);
  localparam int NSEG = 15;

  logic           sclk_q, sdo_q, dcen;
  logic [31:0]    sr;
  logic [5:0]     cnt;
  logic [RES-1:0] inp [4];
  logic [RES-1:0] dac [4];
  logic [3:0]     pd, ldm;
  logic [1:0]     pdm, clr;
  logic [3:0]     sel;

  wire fall = sclk_q & ~sclk;
  wire rise = ~sclk_q & sclk;
  wire go   = fall & ~sync_n & (cnt == 6'd31);

  wire [3:0]     cmd   = sr[26:23];
  wire [3:0]     adr   = sr[22:19];
  wire [RES-1:0] code  = sr[18 -: RES];
  wire [1:0]     f_pdm = sr[4:3];
  wire [3:0]     f_msk = {sr[2:0], sdi};

  always_comb begin
    if (adr == 4'hF)          sel = 4'hF;
    else if (adr[3:2] == 2'b0) sel = 4'b0001 << adr[1:0];
    else                       sel = 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      dcen   <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
      pd     <= '0;
      ldm    <= '0;
      pdm    <= '0;
      clr    <= '0;
      for (int i = 0; i < 4; i++) begin
        inp[i] <= '0;
        dac[i] <= '0;
      end
    end else begin
      sclk_q <= sclk;
      if (sync_n) cnt <= '0;
      else if (fall && cnt != 6'd32) begin
        sr  <= {sr[30:0], sdi};
        cnt <= cnt + 6'd1;
      end
      if (rise) sdo_q <= dcen & sr[31];
      if (go) begin
        case (cmd)
          4'h0: for (int i = 0; i < 4; i++)
                  if (sel[i]) begin
                    inp[i] <= code;
                    if (ldm[i]) dac[i] <= code;
                  end
          4'h1: for (int i = 0; i < 4; i++)
                  if (sel[i]) dac[i] <= inp[i];
          4'h2: for (int i = 0; i < 4; i++)
                  if (sel[i]) begin
                    inp[i] <= code;
                    dac[i] <= code;
                  end else dac[i] <= inp[i];
          4'h3: for (int i = 0; i < 4; i++)
                  if (sel[i]) begin
                    inp[i] <= code;
                    dac[i] <= code;
                  end
          4'h4: begin
            for (int i = 0; i < 4; i++)
              if (f_msk[i]) pd[i] <= (f_pdm != 2'b00);
            if (f_pdm != 2'b00) pdm <= f_pdm;
          end
          4'h5: clr <= f_msk[1:0];
          4'h6: ldm <= f_msk;
          4'h7: begin
            pd   <= '0;
            ldm  <= '0;
            pdm  <= '0;
            clr  <= '0;
            dcen <= 1'b0;
            for (int i = 0; i < 4; i++) begin
              inp[i] <= '0;
              dac[i] <= '0;
            end
          end
          4'h8: dcen <= sdi;
          default: ;
        endcase
      end
    end
  end

  assign sdo     = sdo_q & dcen;
  assign pwr_dn  = pd;
  assign pd_mode = pdm;
  assign clr_sel = clr;

  for (genvar ch = 0; ch < 4; ch++) begin : g_ch
    wire [RES-1:0] oc  = pd[ch] ? '0 : dac[ch];
    wire [3:0]     top = oc[RES-1 -: 4];
    assign dac_code[ch*RES +: RES] = oc;
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      assign seg[ch*NSEG + k] = (top > 4'(k));
    end
  end
endmodule

module qdac_cmd_if_chk #(
  parameter int RES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input logic             sclk,
  input logic             sdo,
  input logic [4*RES-1:0] dac_code,
  input logic [59:0]      seg,
  input logic [3:0]       pwr_dn
);
  for (genvar ch = 0; ch < 4; ch++) begin : g_a
    wire [14:0] s = seg[ch*15 +: 15];
    a_r11_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
      ((s & (s + 15'd1)) == 15'd0));
    a_r7_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn[ch] |-> (dac_code[ch*RES +: RES] == '0 && s == 15'd0));
  end

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |=> ($stable(dac_code) && $stable(pwr_dn)));

  a_r10_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo) |-> ($past(sclk) && !$past(sclk, 2)));
endmodule

bind qdac_cmd_if qdac_cmd_if_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdo(sdo),
  .dac_code(dac_code), .seg(seg), .pwr_dn(pwr_dn)
);

// File: tb/qdac_cmd_if_tb.sv
module qdac_cmd_if_tb;
  localparam int RES = 12;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic             sdo;
  logic [4*RES-1:0] dac_code;
  logic [59:0]      seg;
  logic [3:0]       pwr_dn;
  logic [1:0]       pd_mode, clr_sel;

  always #2.5 clk = ~clk;

  qdac_cmd_if #(.RES(RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .dac_code(dac_code), .seg(seg), .pwr_dn(pwr_dn),
    .pd_mode(pd_mode), .clr_sel(clr_sel)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  logic [RES-1:0] m_inp [4];
  logic [RES-1:0] m_dac [4];
  logic [3:0] m_pd, m_ldm;
  logic [1:0] m_pdm, m_clr;
  logic       m_dcen;
  logic [31:0] cap;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [14:0] therm(input logic [3:0] t);
    logic [14:0] r;
    for (int k = 0; k < 15; k++) r[k] = (t > 4'(k));
    return r;
  endfunction

  function automatic logic [3:0] selm(input logic [3:0] a);
    if (a == 4'hF) return 4'hF;
    if (a < 4'd4) return 4'b0001 << a[1:0];
    return 4'h0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
    m_pd = '0; m_ldm = '0; m_pdm = '0; m_clr = '0; m_dcen = 1'b0;
  endtask

  task automatic m_apply(input logic [31:0] f);
    logic [3:0] s = selm(f[23:20]);
    logic [RES-1:0] c = f[19 -: RES];
    case (f[27:24])
      4'h0: for (int i = 0; i < 4; i++) if (s[i]) begin
              m_inp[i] = c; if (m_ldm[i]) m_dac[i] = c; end
      4'h1: for (int i = 0; i < 4; i++) if (s[i]) m_dac[i] = m_inp[i];
      4'h2: begin
              for (int i = 0; i < 4; i++) if (s[i]) m_inp[i] = c;
              for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
            end
      4'h3: for (int i = 0; i < 4; i++) if (s[i]) begin m_inp[i] = c; m_dac[i] = c; end
      4'h4: begin
              for (int i = 0; i < 4; i++) if (f[i]) m_pd[i] = (f[5:4] != 2'b00);
              if (f[5:4] != 2'b00) m_pdm = f[5:4];
            end
      4'h5: m_clr = f[1:0];
      4'h6: m_ldm = f[3:0];
      4'h7: m_reset();
      4'h8: m_dcen = f[0];
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      logic [RES-1:0] e = m_pd[i] ? '0 : m_dac[i];
      chk(dac_code[i*RES +: RES] == e, req, 64'(dac_code[i*RES +: RES]), 64'(e));
      chk(seg[i*15 +: 15] == therm(e[RES-1 -: 4]), {req, "/R11"},
          64'(seg[i*15 +: 15]), 64'(therm(e[RES-1 -: 4])));
    end
    chk(pwr_dn == m_pd, {req, "/R7"}, 64'(pwr_dn), 64'(m_pd));
    chk(pd_mode == m_pdm, {req, "/R7"}, 64'(pd_mode), 64'(m_pdm));
    chk(clr_sel == m_clr, {req, "/R8"}, 64'(clr_sel), 64'(m_clr));
  endtask

  task automatic send(input logic [31:0] f, input int nbits);
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 31; b > 31 - nbits; b--) begin
      sdi = f[b]; sclk = 1'b1;
      @(negedge clk);
      cap[b] = sdo;
      @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] f, input string req);
    send(f, 32);
    m_apply(f);
    check_all(req);
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [19:0] d);
    return {4'hA, c, a, d};
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1");
    chk(sdo == 1'b0, "R1", 64'(sdo), 64'(0));

    frame(mk(4'h3, 4'h0, 20'hABC00), "R2/R5");
    frame(mk(4'h3, 4'h3, 20'hFFF00), "R5");
    frame(mk(4'h0, 4'h1, 20'h12300), "R5");
    frame(mk(4'h1, 4'h1, 20'h0), "R5");
    frame(mk(4'h3, 4'h7, 20'h55500), "R4");
    frame(mk(4'h3, 4'hF, 20'h80000), "R4");
    frame(mk(4'h0, 4'h2, 20'h7FF00), "R6");
    frame(mk(4'h2, 4'h0, 20'h00100), "R6");
    frame(mk(4'h6, 4'h0, 20'h00005), "R8");
    frame(mk(4'h0, 4'hF, 20'hC0000), "R5");
    frame(mk(4'h5, 4'h0, 20'h00003), "R8");
    frame(mk(4'h4, 4'h0, 20'h00026), "R7");
    frame(mk(4'h4, 4'h0, 20'h00002), "R7");
    for (int c = 9; c < 16; c++) frame(mk(4'(c), 4'hF, 20'hFFFFF), "R12");

    send(mk(4'h3, 4'hF, 20'h44400), 20);
    check_all("R3");
    send(mk(4'h3, 4'h0, 20'h32100), 32);
    m_apply(mk(4'h3, 4'h0, 20'h32100));
    check_all("R3");

    frame(mk(4'h8, 4'h0, 20'h00001), "R10");
    frame(32'hA9C3_5A17, "R10");
    send(mk(4'h9, 4'h0, 20'h0), 32);
    chk(cap == 32'hA9C3_5A17, "R10", 64'(cap), 64'hA9C35A17);
    frame(mk(4'h8, 4'h0, 20'h00000), "R10");
    frame(32'hF9FF_FFFF, "R10");
    send(mk(4'h9, 4'h0, 20'h0), 32);
    chk(cap == 32'h0, "R10", 64'(cap), 64'h0);

    for (int n = 0; n < 250; n++) begin
      logic [3:0] c = 4'($urandom % 16);
      logic [3:0] a;
      if (c == 4'h7 && ($urandom % 6) != 0) c = 4'h0;
      case ($urandom % 4)
        0: a = 4'($urandom % 16);
        1: a = 4'hF;
        default: a = 4'($urandom % 4);
      endcase
      frame({4'($urandom), c, a, 20'($urandom)}, "R2/R4/R5/R6/R7/R12");
    end

    frame(mk(4'h3, 4'hF, 20'hEEE00), "R9");
    frame(mk(4'h4, 4'h0, 20'h0001F), "R9");
    frame(mk(4'h8, 4'h0, 20'h00001), "R9");
    frame(mk(4'h7, 4'h0, 20'h0), "R9");
    chk(sdo == 1'b0, "R9", 64'(sdo), 64'(0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule